// File: doc/BRIEF.md
# Dual Interval Timer Unit

This block holds two 16-bit down-counters that software reaches through an 8-bit register window. The first timer keeps a reloadable 16-bit latch and runs either once per load or periodically, as chosen by a mode input. The second timer always runs once per load. Both count only in cycles where the timebase enable input is high, so the surrounding logic sets the tick rate.

The block owns no interrupt flags and no mask. For each timer it emits a one-cycle set pulse when the counter reaches zero, and a one-cycle clear pulse when software touches a register that acknowledges that timer. A separate flag register elsewhere in the chip takes these pulses. Reads return data one cycle after the read strobe.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both latches and both counters hold 0xFFFF, and every pulse output is low.
- R2: A write to offset 4 or offset 6 replaces only the low byte of the first timer's latch. The first counter is left unchanged, and if a tick comes in the same cycle it still decrements.
- R3: A write to offset 5 stores the byte as the first latch's high byte, loads the counter with {written byte, latch low byte}, and pulses the first clear output in the next cycle.
- R4: A write to offset 7 stores the first latch's high byte and pulses the first clear output, but does not reload the counter.
- R5: A read of offset 4 returns the first counter's low byte and pulses the first clear output. A read of offset 5 returns the high byte with no clear pulse. Reads of offsets 6 and 7 return the latch low and high bytes with no pulse.
- R6: With the free-running input at 1, the first counter steps down from the latch value through 0 and 0xFFFF and then reloads the latch. The period is latch+2 ticks, with a set pulse at every arrival at zero.
- R7: With the free-running input at 0, the first timer gives exactly one set pulse per load, on the first arrival at zero. After that it keeps decrementing and wraps through 0xFFFF with no further pulse.
- R8: A write to offset 8 sets the second latch's low byte only. A write to offset 9 loads the second counter from {written byte, latch low byte} and pulses the second clear output. A read of offset 8 returns the low counter byte and pulses the second clear output. A read of offset 9 returns the high byte. The second timer is always one-shot and ignores the free-running input.
- R9: A counter changes only in tick cycles. A load write in a tick cycle takes precedence: the counter takes the loaded value and no set pulse comes out.
- R10: Read data appears one cycle after the read strobe. A set pulse appears in the cycle after the tick that brought the counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one cycle per timer step |
| t1_freerun_i | input | 1 | 1: first timer free-running; 0: one-shot |
| reg_addr_i | input | 4 | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| t1_set_o | output | 1 | First timer zero event pulse |
| t1_clr_o | output | 1 | First timer acknowledge pulse |
| t2_set_o | output | 1 | Second timer zero event pulse |
| t2_clr_o | output | 1 | Second timer acknowledge pulse |

## Verification
The counting function is run in several ways: one-shot with a small latch over more ticks than the load value, free-running with latch 2 over three full periods, and the second timer with the mode input held high. Together these separate the latch+2 period from a latch+1 period, show the single event in one-shot mode, show that the counter wraps past zero, and show that the second timer ignores the mode input. Further runs place a load write or a latch-low write in a tick cycle, to separate reload precedence from plain decrement. Idle gaps between these runs show that the counter holds when there is no tick.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    OFS_T1_CLO = 4'd4,
    OFS_T1_CHI = 4'd5,
    OFS_T1_LLO = 4'd6,
    OFS_T1_LHI = 4'd7,
    OFS_T2_LO  = 4'd8,
    OFS_T2_HI  = 4'd9
  } dit_ofs_e;

  typedef struct packed {
    logic t1_lat_lo_wr;
    logic t1_lat_hi_wr;
    logic t1_load;
    logic t1_lo_rd;
    logic t2_lat_lo_wr;
    logic t2_load;
    logic t2_lo_rd;
  } dit_strobe_t;
endpackage

// File: rtl/dit_decode.sv
module dit_decode
  import dit_pkg::*;
(
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output dit_strobe_t       strb_o
);
  always_comb begin
    strb_o              = '0;
    strb_o.t1_lat_lo_wr = reg_wr_i && (reg_addr_i == OFS_T1_CLO || reg_addr_i == OFS_T1_LLO);
    strb_o.t1_lat_hi_wr = reg_wr_i && (reg_addr_i == OFS_T1_CHI || reg_addr_i == OFS_T1_LHI);
    strb_o.t1_load      = reg_wr_i && (reg_addr_i == OFS_T1_CHI);
    strb_o.t1_lo_rd     = reg_rd_i && (reg_addr_i == OFS_T1_CLO);
    strb_o.t2_lat_lo_wr = reg_wr_i && (reg_addr_i == OFS_T2_LO);
    strb_o.t2_load      = reg_wr_i && (reg_addr_i == OFS_T2_HI);
    strb_o.t2_lo_rd     = reg_rd_i && (reg_addr_i == OFS_T2_LO);
  end
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int DW          = 8,
  parameter bit CAN_FREERUN = 1'b1,
  localparam int CW         = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          freerun_i,
  input  logic          lat_lo_wr_i,
  input  logic          lat_hi_wr_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] latch_o,
  output logic          evt_o
);
  logic [CW-1:0] cnt_q, latch_q, nxt;
  logic          armed_q, fr, fire;

  assign fr = CAN_FREERUN && freerun_i;

  // next value on a tick: periodic reload after the 0xFFFF step
  always_comb begin
    if (fr && (cnt_q == '1)) nxt = latch_q;
    else                     nxt = cnt_q - 1'b1;
    fire = tick_i && !load_i && (nxt == '0) && (fr || armed_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      latch_q <= '1;
      armed_q <= 1'b0;
      evt_o   <= 1'b0;
    end else begin
      evt_o <= fire;
      if (lat_lo_wr_i) latch_q[DW-1:0]  <= wdata_i;
      if (lat_hi_wr_i) latch_q[CW-1:DW] <= wdata_i;
      if (load_i) begin
        cnt_q   <= {wdata_i, latch_q[DW-1:0]};
        armed_q <= 1'b1;
      end else if (tick_i) begin
        cnt_q <= nxt;
        if (fire) armed_q <= 1'b0;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;

  // R9: no tick and no load leaves the counter alone
  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R9: load wins over decrement
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == {$past(wdata_i), $past(latch_q[DW-1:0])}) && !evt_o);
  // R10: an event pulse coincides with a zero counter
  p_evt_at_zero_r10: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> (cnt_q == '0));
  // R6: free-running reload after 0xFFFF
  p_freerun_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (fr && tick_i && !load_i && cnt_q == '1) |=> (cnt_q == $past(latch_q)));
  // R7: one-shot disarms on its event
  p_oneshot_once_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && !fr) |=> !armed_q);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              t1_freerun_i,
  input  logic [3:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              t1_set_o,
  output logic              t1_clr_o,
  output logic              t2_set_o,
  output logic              t2_clr_o
);
  localparam int CW = 2 * DW;

  dit_strobe_t   strb;
  logic [CW-1:0] t1_cnt, t1_lat, t2_cnt, t2_lat;
  logic [DW-1:0] rd_mux;

  dit_decode u_dec (
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .strb_o     (strb)
  );

  dit_counter #(.DW(DW), .CAN_FREERUN(1'b1)) u_t1 (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .freerun_i   (t1_freerun_i),
    .lat_lo_wr_i (strb.t1_lat_lo_wr),
    .lat_hi_wr_i (strb.t1_lat_hi_wr),
    .load_i      (strb.t1_load),
    .wdata_i     (reg_wdata_i),
    .cnt_o       (t1_cnt),
    .latch_o     (t1_lat),
    .evt_o       (t1_set_o)
  );

  dit_counter #(.DW(DW), .CAN_FREERUN(1'b0)) u_t2 (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .freerun_i   (1'b0),
    .lat_lo_wr_i (strb.t2_lat_lo_wr),
    .lat_hi_wr_i (strb.t2_load),
    .load_i      (strb.t2_load),
    .wdata_i     (reg_wdata_i),
    .cnt_o       (t2_cnt),
    .latch_o     (t2_lat),
    .evt_o       (t2_set_o)
  );

  always_comb begin
    case (reg_addr_i)
      OFS_T1_CLO: rd_mux = t1_cnt[DW-1:0];
      OFS_T1_CHI: rd_mux = t1_cnt[CW-1:DW];
      OFS_T1_LLO: rd_mux = t1_lat[DW-1:0];
      OFS_T1_LHI: rd_mux = t1_lat[CW-1:DW];
      OFS_T2_LO:  rd_mux = t2_cnt[DW-1:0];
      OFS_T2_HI:  rd_mux = t2_cnt[CW-1:DW];
      default:    rd_mux = '0;
    endcase
  end

  logic unused_t2_lat;
  assign unused_t2_lat = ^t2_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      t1_clr_o    <= 1'b0;
      t2_clr_o    <= 1'b0;
    end else begin
      if (reg_rd_i) reg_rdata_o <= rd_mux;
      t1_clr_o <= strb.t1_lat_hi_wr | strb.t1_lo_rd;
      t2_clr_o <= strb.t2_load | strb.t2_lo_rd;
    end
  end

  // R3: counter-high write acknowledges the first timer
  p_t1_clr_on_load_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == 4'd5) |=> t1_clr_o);
  // R5: low counter read acknowledges the first timer
  p_t1_clr_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_addr_i == 4'd4) |=> t1_clr_o);
  // R8: second timer acknowledge only on its own accesses
  p_t2_clr_source_r8: assert property (@(posedge clk) disable iff (rst)
    (!reg_rd_i && !reg_wr_i) |=> !t2_clr_o);
  // R10: read data holds when no read is made
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, tick, fr, wr, rd;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       s1, c1, s2, c2;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst(rst), .tick_i(tick), .t1_freerun_i(fr),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .t1_set_o(s1), .t1_clr_o(c1), .t2_set_o(s2), .t2_clr_o(c2)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample at the following negedge
  task automatic cyc(input logic tk, input logic w, input logic r,
                     input logic [3:0] a, input logic [7:0] d);
    tick = tk; wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr = 1'b0; rd = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] v);
    cyc(1'b0, 1'b0, 1'b1, a, 8'h00);
    v = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 set/clr low", {12'h0, s1, c1, s2, c2}, 16'h0);
    rreg(4'd6, v); chk("R1 t1 latch lo", {8'h0, v}, 16'h00FF);
    chk("R5 latch read no clr", {15'h0, c1}, 16'h0);
    rreg(4'd7, v); chk("R1 t1 latch hi", {8'h0, v}, 16'h00FF);
    rreg(4'd5, v); chk("R1 t1 cnt hi", {8'h0, v}, 16'h00FF);
    chk("R5 hi read no clr", {15'h0, c1}, 16'h0);
    rreg(4'd4, v); chk("R1 t1 cnt lo", {8'h0, v}, 16'h00FF);
    chk("R5 lo read clr", {15'h0, c1}, 16'h1);
    rreg(4'd9, v); chk("R1 t2 cnt hi", {8'h0, v}, 16'h00FF);
  endtask

  task automatic t_load_and_latch;
    logic [7:0] v;
    wreg(4'd4, 8'h05);
    chk("R2 lo write no clr", {15'h0, c1}, 16'h0);
    rreg(4'd5, v); chk("R2 cnt untouched", {8'h0, v}, 16'h00FF);
    wreg(4'd5, 8'h00);
    chk("R3 load clr pulse", {15'h0, c1}, 16'h1);
    rreg(4'd4, v); chk("R3 cnt lo loaded", {8'h0, v}, 16'h0005);
    wreg(4'd7, 8'h12);
    chk("R4 latch hi clr pulse", {15'h0, c1}, 16'h1);
    rreg(4'd5, v); chk("R4 no reload hi", {8'h0, v}, 16'h0000);
    rreg(4'd7, v); chk("R4 latch hi stored", {8'h0, v}, 16'h0012);
    rreg(4'd6, v); chk("R5 latch lo read", {8'h0, v}, 16'h0005);
  endtask

  task automatic t_oneshot;
    logic [7:0] v;
    int ev = 0;
    fr = 1'b0;
    wreg(4'd4, 8'h03);
    wreg(4'd5, 8'h00);
    for (int i = 1; i <= 8; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
      if (s1) begin
        ev++;
        chk("R7 event at 3rd tick", 16'(i), 16'd3);
      end
    end
    chk("R7 single event", 16'(ev), 16'd1);
    rreg(4'd4, v); chk("R7 wrapped lo", {8'h0, v}, 16'h00FB);
    rreg(4'd5, v); chk("R7 wrapped hi", {8'h0, v}, 16'h00FF);
  endtask

  task automatic t_freerun;
    logic [7:0] v;
    int ev = 0;
    fr = 1'b1;
    wreg(4'd4, 8'h02);
    wreg(4'd5, 8'h00);
    for (int i = 1; i <= 12; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
      if (s1) begin
        ev++;
        chk("R6 event at zero, period 4", 16'(i % 4), 16'd2);
      end
    end
    chk("R6 event count", 16'(ev), 16'd3);
    rreg(4'd4, v); chk("R6 reloaded lo", {8'h0, v}, 16'h0002);
    fr = 1'b0;
  endtask

  task automatic t_precedence;
    logic [7:0] v;
    cyc(1'b1, 1'b1, 1'b0, 4'd5, 8'h01);
    chk("R9 no event on load", {15'h0, s1}, 16'h0);
    rreg(4'd4, v); chk("R9 load wins lo", {8'h0, v}, 16'h0002);
    rreg(4'd5, v); chk("R9 load wins hi", {8'h0, v}, 16'h0001);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    rreg(4'd4, v); chk("R9 hold without tick", {8'h0, v}, 16'h0002);
    cyc(1'b1, 1'b1, 1'b0, 4'd6, 8'h77);
    rreg(4'd4, v); chk("R2 tick still decrements", {8'h0, v}, 16'h0001);
    rreg(4'd6, v); chk("R2 latch lo via 6", {8'h0, v}, 16'h0077);
  endtask

  task automatic t_timer2;
    logic [7:0] v;
    int ev = 0;
    fr = 1'b1;
    wreg(4'd8, 8'h04);
    chk("R8 lo write no clr", {15'h0, c2}, 16'h0);
    wreg(4'd9, 8'h00);
    chk("R8 load clr", {15'h0, c2}, 16'h1);
    for (int i = 1; i <= 6; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
      if (s2) begin
        ev++;
        chk("R10 t2 event after 4th tick", 16'(i), 16'd4);
      end
    end
    chk("R8 one-shot despite mode", 16'(ev), 16'd1);
    rreg(4'd9, v); chk("R8 hi read", {8'h0, v}, 16'h00FF);
    chk("R8 hi read no clr", {15'h0, c2}, 16'h0);
    rreg(4'd8, v); chk("R8 lo read", {8'h0, v}, 16'h00FE);
    chk("R8 lo read clr", {15'h0, c2}, 16'h1);
    fr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b0; fr = 1'b0; wr = 1'b0; rd = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_and_latch();
    t_oneshot();
    t_freerun();
    t_precedence();
    t_timer2();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule